// File: doc/BRIEF.md
# Dual-Bus Ready Synchroniser

This block merges the wait-state requests of two system buses into one ready signal for a processor. It retimes that signal to the processor clock. Each bus supplies a ready line and an active-low enable. A bus's ready line is taken into account only while that bus's enable is low. The qualified lines are ORed into a single combined ready.

The combined ready reaches the output through a falling-edge register. A mode input selects how much protection against asynchronous timing the path gets:

- **Two-stage mode** (mode input low): a rising combined ready must first be caught by a rising-edge register. It passes to the output only at the following falling edge, and only if it is still present there. A falling combined ready skips the first register and clears the output at the next falling edge.
- **Single-stage mode** (mode input high): the rising-edge register is ignored, and the output simply samples the combined ready on each falling edge.

The mode input is looked at on every falling edge. A device that is known to meet setup can therefore use the faster path on one bus cycle, and an unsynchronised device can use the slower path on the next.

Top module: `rdy_sync`

## Requirements
- R1: A bus's ready input contributes to the combined ready only while that bus's enable input (`en_a_n` or `en_b_n`) is 0. With an enable at 1, that bus's ready has no effect on `ready_out`.
- R2: While `rst_n` is 0, `ready_out` is 0 whatever the other inputs are, and both internal stages are cleared.
- R3: With `async_mode` = 0, `ready_out` rises at a falling edge of `clk` only if the combined ready was 1 at the preceding rising edge and is still 1 at that falling edge. An input raised just after a rising edge therefore shows at the output one and a half clock periods later.
- R4: A combined ready of 0 at a falling edge of `clk` drives `ready_out` to 0 at that edge, in either mode. Deassertion takes half a clock period from a rising-edge-aligned change.
- R5: With `async_mode` = 1, `ready_out` takes the combined ready sampled at each falling edge of `clk`, regardless of the rising-edge stage. Assertion takes half a clock period.
- R6: The value of `async_mode` at a given falling edge alone decides that edge's update. A switch to 1 passes a fresh ready at once. A switch to 0 while the input stays high keeps `ready_out` high.
- R7: Outside reset, `ready_out` changes only at falling edges of `clk`. Its value is unchanged across a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; stage one on rising edge, output stage on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdy_a | input | 1 | Ready request from bus A |
| en_a_n | input | 1 | Active-low qualifier for `rdy_a` |
| rdy_b | input | 1 | Ready request from bus B |
| en_b_n | input | 1 | Active-low qualifier for `rdy_b` |
| async_mode | input | 1 | 0 = two-stage synchronisation, 1 = single-stage |
| ready_out | output | 1 | Synchronised ready to the processor |

## Verification
A stuck or stale rising-edge stage appears at the ports within one falling edge in two-stage mode. `ready_out` then either rises for an input that arrived after the last rising edge, or fails to rise one and a half periods after a rising-edge-aligned request. A mis-wired mode mux shows as a half-period rise where one and a half was due, or the reverse. A bad qualifier shows as a ready passing from a disabled bus at the next falling edge. Deassertion faults show as `ready_out` still high half a period after the request drops.

// File: rtl/rdy_sync_pkg.sv
package rdy_sync_pkg;

  // A bus request counts only with its active-low enable asserted.
  function automatic logic bus_qualify(input logic rdy, input logic en_n);
    return rdy & ~en_n;
  endfunction

  // Next value of the falling-edge stage.
  function automatic logic stage2_next(input logic single_stage,
                                       input logic s1,
                                       input logic comb);
    return single_stage ? comb : (s1 & comb);
  endfunction

endpackage

// File: rtl/rdy_combine.sv
module rdy_combine #(
  parameter int N_BUS = 2
) (
  input  logic [N_BUS-1:0] rdy,
  input  logic [N_BUS-1:0] en_n,
  output logic             any_rdy
);
  import rdy_sync_pkg::*;

  logic [N_BUS-1:0] qual;

  for (genvar g = 0; g < N_BUS; g++) begin : g_bus
    assign qual[g] = bus_qualify(rdy[g], en_n[g]);
  end

  assign any_rdy = |qual;
endmodule

// File: rtl/rdy_stage_rise.sv
module rdy_stage_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/rdy_stage_fall.sv
module rdy_stage_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic single_stage,
  input  logic s1,
  input  logic comb,
  output logic q
);
  import rdy_sync_pkg::*;

  logic d;
  assign d = stage2_next(single_stage, s1, comb);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/rdy_sync.sv
module rdy_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_a,
  input  logic en_a_n,
  input  logic rdy_b,
  input  logic en_b_n,
  input  logic async_mode,
  output logic ready_out
);
  localparam int N_BUS = 2;

  logic [N_BUS-1:0] rdy_vec;
  logic [N_BUS-1:0] en_vec;
  logic             comb_rdy;
  logic             s1_q;

  assign rdy_vec = {rdy_b, rdy_a};
  assign en_vec  = {en_b_n, en_a_n};

  rdy_combine #(.N_BUS(N_BUS)) u_comb (
    .rdy     (rdy_vec),
    .en_n    (en_vec),
    .any_rdy (comb_rdy)
  );

  rdy_stage_rise u_s1 (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (comb_rdy),
    .q     (s1_q)
  );

  rdy_stage_fall u_s2 (
    .clk          (clk),
    .rst_n        (rst_n),
    .single_stage (async_mode),
    .s1           (s1_q),
    .comb         (comb_rdy),
    .q            (ready_out)
  );
endmodule

// File: rtl/rdy_sync_chk.sv
module rdy_sync_chk (
  input logic clk,
  input logic rst_n,
  input logic en_a_n,
  input logic en_b_n,
  input logic async_mode,
  input logic comb_rdy,
  input logic s1_q,
  input logic ready_out
);
  // R2: reset holds the output low
  always @(posedge clk) begin
    if (!rst_n) assert_reset_low_R2: assert (!ready_out);
  end

  // R1: both buses disabled means no combined request
  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a_n && en_b_n) |-> !comb_rdy);

  // R3: two-stage mode without stage one never raises the output
  assert_two_stage_block_R3: assert property (@(negedge clk) disable iff (!rst_n)
    (!async_mode && !s1_q) |=> !ready_out);

  // R3: two-stage mode with both stages agreeing raises the output
  assert_two_stage_pass_R3: assert property (@(negedge clk) disable iff (!rst_n)
    (!async_mode && s1_q && comb_rdy) |=> ready_out);

  // R4: an absent request clears the output at that falling edge
  assert_deassert_fast_R4: assert property (@(negedge clk) disable iff (!rst_n)
    !comb_rdy |=> !ready_out);

  // R5, R6: single-stage mode follows the combined request directly
  assert_single_stage_R5: assert property (@(negedge clk) disable iff (!rst_n)
    async_mode |=> (ready_out == $past(comb_rdy)));
endmodule

bind rdy_sync rdy_sync_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_a_n     (en_a_n),
  .en_b_n     (en_b_n),
  .async_mode (async_mode),
  .comb_rdy   (comb_rdy),
  .s1_q       (s1_q),
  .ready_out  (ready_out)
);

// File: tb/sim_rdy_sync.sv
module sim_rdy_sync;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rdy_a = 1'b0, en_a_n = 1'b1, rdy_b = 1'b0, en_b_n = 1'b1;
  logic async_mode = 1'b0;
  logic ready_out;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  rdy_sync u0 (
    .clk(clk), .rst_n(rst_n), .rdy_a(rdy_a), .en_a_n(en_a_n),
    .rdy_b(rdy_b), .en_b_n(en_b_n), .async_mode(async_mode),
    .ready_out(ready_out)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (ready_out !== exp) begin
      errors++;
      $display("FAIL %s: ready_out=%b expected %b at %0t", req, ready_out, exp, $time);
    end
  endtask

  task automatic after_rise();  @(posedge clk); #2; endtask
  task automatic after_fall();  @(negedge clk); #2; endtask

  task automatic go_idle();
    after_rise();
    rdy_a = 0; rdy_b = 0; en_a_n = 1; en_b_n = 1;
    after_fall(); after_fall();
  endtask

  task automatic t_reset();
    async_mode = 1; rdy_a = 1; en_a_n = 0;
    after_fall(); check(1'b0, "R2 reset with request");
    after_fall(); check(1'b0, "R2 reset held");
    after_rise(); rdy_a = 0; en_a_n = 1; async_mode = 0;
    rst_n = 1;
    after_fall(); check(1'b0, "R2 after release");
  endtask

  task automatic t_qualify();
    go_idle();
    after_rise(); async_mode = 1; rdy_a = 1; en_a_n = 1; rdy_b = 0; en_b_n = 0;
    after_fall(); check(1'b0, "R1 bus A disabled ignored");
    after_rise(); en_a_n = 0;
    after_fall(); check(1'b1, "R1 bus A enabled");
    after_rise(); rdy_a = 0; rdy_b = 1; en_b_n = 1;
    after_fall(); check(1'b0, "R1 bus B disabled ignored");
    after_rise(); en_b_n = 0;
    after_fall(); check(1'b1, "R1 bus B enabled");
  endtask

  task automatic t_two_stage();
    go_idle();
    after_rise(); async_mode = 0; rdy_a = 1; en_a_n = 0;
    after_fall(); check(1'b0, "R3 half period still low");
    after_rise(); check(1'b0, "R7 stable across rising edge");
    after_fall(); check(1'b1, "R3 high after one and a half periods");
    after_rise(); check(1'b1, "R7 high across rising edge");
    rdy_a = 0;
    after_fall(); check(1'b0, "R4 two-stage deassert half period");
  endtask

  task automatic t_glitch();
    go_idle();
    after_rise(); async_mode = 0; rdy_b = 1; en_b_n = 0;
    after_rise(); rdy_b = 0;   // stage one caught it, input gone before fall
    after_fall(); check(1'b0, "R3 dropped request blocked");
  endtask

  task automatic t_single_stage();
    go_idle();
    after_rise(); async_mode = 1; rdy_a = 1; en_a_n = 0;
    after_fall(); check(1'b1, "R5 half period assert");
    after_rise(); rdy_a = 0;
    after_fall(); check(1'b0, "R4 single-stage deassert");
  endtask

  task automatic t_mode_switch();
    go_idle();
    after_rise(); async_mode = 0;
    after_fall();
    after_rise(); async_mode = 1; rdy_b = 1; en_b_n = 0;
    after_fall(); check(1'b1, "R6 switch to single stage passes at once");
    after_rise(); async_mode = 0;
    after_fall(); check(1'b1, "R6 switch to two-stage keeps high");
    after_rise(); rdy_b = 0; async_mode = 1;
    after_fall(); check(1'b0, "R6 switch with drop");
  endtask

  initial begin : watchdog
    #1000000;
    errors++;
    $display("FAIL watchdog: ready_out=%b expected finish", ready_out);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_qualify();
    t_two_stage();
    t_glitch();
    t_single_stage();
    t_mode_switch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule